// File: doc/BRIEF.md
# Chip-Select Segment Window Decoder

The block keeps one window register for each chip select of a serial-flash controller. Each register places that chip select's slice of a fixed flash address window in 8 MB granules. A granule number is physical address bits 30:23. A host address presented on the lookup port is resolved combinationally to a chip select and a byte offset within that chip select's slice. If no slice matches, the port reports a miss, and the host path that uses it then returns zero for reads and drops writes.

Writes to a window register go through a policy stage. The stage puts back fields that are fixed in hardware and refuses slices that lie outside the flash window. It also reports two problems that it still lets through: a slice whose start is not a multiple of its size, and a slice that collides with another chip select's slice. Each outcome drives a one-cycle flag that software or a monitor can count.

Top module: `seg_window_decoder`

## Requirements
- R1: A register reads as {end granule in bits 31:24, start granule in bits 23:16, 16'h0 in bits 15:0}. A read with a chip-select index at or above NUM_CS returns 0.
- R2: After reset, chip select 0 spans FIRST_SIZE_G granules starting at WIN_BASE_G. Each later chip select follows the previous one directly and spans REST_SIZE_G granules.
- R3: For chip selects marked in START_FIXED, a written start is replaced by the reset start. For chip selects marked in END_FIXED, a written end is replaced by the reset end. If either replacement changes the written value, err_fixed_o pulses.
- R4: After fixed fields are applied, a write is refused if its end is at or below WIN_BASE_G, or if its start is above WIN_BASE_G+WIN_SPAN_G. The register keeps its old value and err_reject_o pulses. No misalignment or overlap flag is raised for a refused write.
- R5: An accepted slice with end > start whose start is not a whole multiple of (end - start) is stored, and err_misalign_o pulses.
- R6: An accepted slice with end > start that intersects a non-empty slice of any other chip select (new end > other start and new start < other end) is stored, and err_overlap_o pulses.
- R7: A write whose 32-bit data equals the current register read value, or that targets an index at or above NUM_CS, changes nothing and raises no flag.
- R8: A lookup hits chip select i when end_i > start_i and start_i <= lk_addr_i[30:23] < end_i. The offset is then lk_addr_i minus start_i times 8 MB.
- R9: A lookup that hits no slice drives lk_hit_o=0, lk_cs_o=0, lk_off_o=0.
- R10: When several slices match a lookup, the lowest-numbered chip select is reported.
- R11: The error flags are registered. They are high only in the cycle after the write that caused them and are low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_cs_i | input | CS_W | Chip select whose register is written |
| wr_data_i | input | 32 | Write data |
| rd_cs_i | input | CS_W | Chip select whose register is read |
| rd_data_o | output | 32 | Read data |
| lk_addr_i | input | 31 | Lookup byte address, bits 30:0 |
| lk_hit_o | output | 1 | Lookup matched a slice |
| lk_cs_o | output | CS_W | Matched chip select |
| lk_off_o | output | 31 | Byte offset within the matched slice |
| err_fixed_o | output | 1 | A fixed field was corrected |
| err_reject_o | output | 1 | A write was refused for bounds |
| err_misalign_o | output | 1 | An accepted slice is misaligned |
| err_overlap_o | output | 1 | An accepted slice overlaps another |

## Verification
The bench first reads back every register during reset. It then probes lookups at the first and last granule of each default slice and just outside the window, which separates off-by-one errors in the start bound from those in the end bound. Directed writes then exercise each kind of problem on its own: a fixed start, a fixed end, a slice below the base, a slice past the limit, a misaligned slice, an overlapping slice, a rewrite of the same value, an out-of-range index, an empty slice and nonzero low data bits. A lookup into an overlapped region shows whether priority goes to the lower index. A long pseudo-random run of writes and lookups follows, with a behavioural model compared every cycle, so that combinations of problems are reached that the directed cases do not cover.

// File: rtl/seg_win_pkg.sv
package seg_win_pkg;
  localparam int G_W   = 8;   // granule index width (addr bits 30:23)
  localparam int OFF_W = 23;  // byte bits inside one 8 MB granule
  localparam int LA_W  = G_W + OFF_W;

  typedef struct packed {
    logic [G_W-1:0] end_g;
    logic [G_W-1:0] start_g;
  } seg_t;

  typedef struct packed {
    logic fixed;
    logic reject;
    logic misalign;
    logic overlap;
  } seg_flags_t;

  function automatic seg_t default_seg(int idx, int base, int first, int rest);
    seg_t r;
    int   s;
    int   e;
    s = base + ((idx == 0) ? 0 : first + (idx - 1) * rest);
    e = s + ((idx == 0) ? first : rest);
    r.start_g = s[G_W-1:0];
    r.end_g   = e[G_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import seg_win_pkg::*;
#(
  parameter int NUM_CS       = 5,
  parameter int CS_W         = 3,
  parameter int WIN_BASE_G   = 64,
  parameter int FIRST_SIZE_G = 8,
  parameter int REST_SIZE_G  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [CS_W-1:0]        cs_i,
  input  seg_t                   seg_i,
  input  logic [CS_W-1:0]        rd_cs_i,
  output seg_t [NUM_CS-1:0]      segs_o,
  output logic [31:0]            rd_data_o
);
  seg_t segs_q [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_reg
    localparam seg_t DFLT = default_seg(i, WIN_BASE_G, FIRST_SIZE_G, REST_SIZE_G);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              segs_q[i] <= DFLT;
      else if (we_i && (cs_i == CS_W'(i)))      segs_q[i] <= seg_i;
    end
    assign segs_o[i] = segs_q[i];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (rd_cs_i == CS_W'(i)) rd_data_o = {segs_q[i], 16'h0000};
    end
  end
endmodule

// File: rtl/seg_wr_policy.sv
module seg_wr_policy
  import seg_win_pkg::*;
#(
  parameter int                NUM_CS      = 5,
  parameter int                CS_W        = 3,
  parameter int                WIN_BASE_G  = 64,
  parameter int                WIN_SPAN_G  = 32,
  parameter logic [NUM_CS-1:0] START_FIXED = 1,
  parameter logic [NUM_CS-1:0] END_FIXED   = 0
) (
  input  logic              wr_en_i,
  input  logic [CS_W-1:0]   wr_cs_i,
  input  logic [31:0]       wr_data_i,
  input  seg_t [NUM_CS-1:0] segs_i,
  input  seg_t [NUM_CS-1:0] dflt_i,
  output logic              commit_o,
  output seg_t              new_o,
  output seg_flags_t        flags_o
);
  localparam logic [G_W:0] BASE9  = (G_W+1)'(WIN_BASE_G);
  localparam logic [G_W:0] LIMIT9 = (G_W+1)'(WIN_BASE_G + WIN_SPAN_G);

  seg_t           raw, cur, dcur, nv;
  logic           cs_ok, sfix, efix, same, act;
  logic           fixed, reject, nonempty, misalign, overlap;
  logic [G_W-1:0] size_g;

  always_comb begin
    cs_ok = 1'b0;
    cur   = '0;
    dcur  = '0;
    sfix  = 1'b0;
    efix  = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (wr_cs_i == CS_W'(i)) begin
        cs_ok = 1'b1;
        cur   = segs_i[i];
        dcur  = dflt_i[i];
        sfix  = START_FIXED[i];
        efix  = END_FIXED[i];
      end
    end
    raw.end_g   = wr_data_i[31:24];
    raw.start_g = wr_data_i[23:16];
    same        = (wr_data_i == {cur, 16'h0000});
    act         = wr_en_i && cs_ok && !same;

    nv = raw;
    if (sfix) nv.start_g = dcur.start_g;
    if (efix) nv.end_g   = dcur.end_g;
    fixed = (nv != raw);

    reject = ({1'b0, nv.end_g} <= BASE9) || ({1'b0, nv.start_g} > LIMIT9);

    nonempty = nv.end_g > nv.start_g;
    size_g   = nonempty ? (nv.end_g - nv.start_g) : G_W'(1);
    misalign = nonempty && ((nv.start_g % size_g) != '0);

    overlap = 1'b0;
    for (int j = 0; j < NUM_CS; j++) begin
      if ((wr_cs_i != CS_W'(j)) && nonempty &&
          (segs_i[j].end_g > segs_i[j].start_g) &&
          (nv.end_g > segs_i[j].start_g) && (nv.start_g < segs_i[j].end_g))
        overlap = 1'b1;
    end

    commit_o = act && !reject;
    new_o    = nv;
    flags_o  = '0;
    if (act) begin
      flags_o.fixed    = fixed;
      flags_o.reject   = reject;
      flags_o.misalign = !reject && misalign;
      flags_o.overlap  = !reject && overlap;
    end
  end
endmodule

// File: rtl/seg_lookup.sv
module seg_lookup
  import seg_win_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int CS_W   = 3
) (
  input  seg_t [NUM_CS-1:0] segs_i,
  input  logic [LA_W-1:0]   addr_i,
  output logic              hit_o,
  output logic [CS_W-1:0]   cs_o,
  output logic [LA_W-1:0]   off_o
);
  logic [G_W-1:0]    gran;
  logic [NUM_CS-1:0] match;

  assign gran = addr_i[LA_W-1:OFF_W];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_match
    assign match[i] = (segs_i[i].end_g > segs_i[i].start_g) &&
                      (gran >= segs_i[i].start_g) && (gran < segs_i[i].end_g);
  end

  // descending scan so the lowest index is written last
  always_comb begin
    hit_o = 1'b0;
    cs_o  = '0;
    off_o = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        cs_o  = CS_W'(i);
        off_o = {gran - segs_i[i].start_g, addr_i[OFF_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/seg_window_decoder.sv
module seg_window_decoder
  import seg_win_pkg::*;
#(
  parameter int                NUM_CS       = 5,
  parameter int                WIN_BASE_G   = 64,
  parameter int                WIN_SPAN_G   = 32,
  parameter int                FIRST_SIZE_G = 8,
  parameter int                REST_SIZE_G  = 4,
  parameter logic [NUM_CS-1:0] START_FIXED  = 1,
  parameter logic [NUM_CS-1:0] END_FIXED    = 0,
  localparam int               CS_W         = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [CS_W-1:0] wr_cs_i,
  input  logic [31:0]     wr_data_i,
  input  logic [CS_W-1:0] rd_cs_i,
  output logic [31:0]     rd_data_o,
  input  logic [30:0]     lk_addr_i,
  output logic            lk_hit_o,
  output logic [CS_W-1:0] lk_cs_o,
  output logic [30:0]     lk_off_o,
  output logic            err_fixed_o,
  output logic            err_reject_o,
  output logic            err_misalign_o,
  output logic            err_overlap_o
);
  seg_t [NUM_CS-1:0] segs;
  seg_t [NUM_CS-1:0] dflt;
  seg_t              new_seg;
  logic              commit;
  seg_flags_t        flags_d, flags_q;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_dflt
    assign dflt[i] = default_seg(i, WIN_BASE_G, FIRST_SIZE_G, REST_SIZE_G);
  end

  seg_wr_policy #(
    .NUM_CS(NUM_CS), .CS_W(CS_W), .WIN_BASE_G(WIN_BASE_G), .WIN_SPAN_G(WIN_SPAN_G),
    .START_FIXED(START_FIXED), .END_FIXED(END_FIXED)
  ) i_policy (
    .wr_en_i(wr_en_i), .wr_cs_i(wr_cs_i), .wr_data_i(wr_data_i),
    .segs_i(segs), .dflt_i(dflt),
    .commit_o(commit), .new_o(new_seg), .flags_o(flags_d)
  );

  seg_bank #(
    .NUM_CS(NUM_CS), .CS_W(CS_W), .WIN_BASE_G(WIN_BASE_G),
    .FIRST_SIZE_G(FIRST_SIZE_G), .REST_SIZE_G(REST_SIZE_G)
  ) i_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(commit), .cs_i(wr_cs_i), .seg_i(new_seg),
    .rd_cs_i(rd_cs_i), .segs_o(segs), .rd_data_o(rd_data_o)
  );

  seg_lookup #(.NUM_CS(NUM_CS), .CS_W(CS_W)) i_lookup (
    .segs_i(segs), .addr_i(lk_addr_i),
    .hit_o(lk_hit_o), .cs_o(lk_cs_o), .off_o(lk_off_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign err_fixed_o    = flags_q.fixed;
  assign err_reject_o   = flags_q.reject;
  assign err_misalign_o = flags_q.misalign;
  assign err_overlap_o  = flags_q.overlap;
endmodule

// File: rtl/seg_window_checker.sv
module seg_window_checker
  import seg_win_pkg::*;
#(
  parameter int                NUM_CS       = 5,
  parameter int                CS_W         = 3,
  parameter int                WIN_BASE_G   = 64,
  parameter int                FIRST_SIZE_G = 8,
  parameter int                REST_SIZE_G  = 4,
  parameter logic [NUM_CS-1:0] START_FIXED  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input seg_t [NUM_CS-1:0] segs,
  input logic              lk_hit_o,
  input logic [CS_W-1:0]   lk_cs_o,
  input logic [30:0]       lk_off_o,
  input logic              err_fixed_o,
  input logic              err_reject_o,
  input logic              err_misalign_o,
  input logic              err_overlap_o
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_lock
    if (START_FIXED[i]) begin : g_on
      localparam seg_t D = default_seg(i, WIN_BASE_G, FIRST_SIZE_G, REST_SIZE_G);
      AST_START_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        segs[i].start_g == D.start_g); // R3
    end
  end

  AST_REJECT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_reject_o |-> $stable(segs)); // R4

  AST_REJECT_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_reject_o |-> !err_misalign_o && !err_overlap_o); // R4

  AST_MISS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_cs_o == '0) && (lk_off_o == '0)); // R9

  AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_fixed_o || err_reject_o || err_misalign_o || err_overlap_o) |-> $past(wr_en_i)); // R11
endmodule

bind seg_window_decoder seg_window_checker #(
  .NUM_CS(NUM_CS), .CS_W(CS_W), .WIN_BASE_G(WIN_BASE_G),
  .FIRST_SIZE_G(FIRST_SIZE_G), .REST_SIZE_G(REST_SIZE_G), .START_FIXED(START_FIXED)
) i_seg_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .segs(segs),
  .lk_hit_o(lk_hit_o), .lk_cs_o(lk_cs_o), .lk_off_o(lk_off_o),
  .err_fixed_o(err_fixed_o), .err_reject_o(err_reject_o),
  .err_misalign_o(err_misalign_o), .err_overlap_o(err_overlap_o)
);

// File: tb/test_seg_window_decoder.sv
module test_seg_window_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_cs = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_cs = '0;
  logic [30:0] lk_addr = '0;
  logic [31:0] rd_data;
  logic        lk_hit;
  logic [2:0]  lk_cs;
  logic [30:0] lk_off;
  logic        f_fix, f_rej, f_mis, f_ov;

  int checks = 0;
  int errors = 0;

  // reference state: granule starts / ends
  int m_s [5] = '{64, 72, 76, 80, 84};
  int m_e [5] = '{72, 76, 80, 84, 88};
  logic [3:0] exp_flags = '0;
  string      flag_tag = "R11";
  logic [3:0] pend_flags;
  string      pend_tag;
  string      rd_tag = "R1";
  int         lcg = 12345;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_window_decoder #(
    .NUM_CS(5), .WIN_BASE_G(64), .WIN_SPAN_G(32), .FIRST_SIZE_G(8), .REST_SIZE_G(4),
    .START_FIXED(5'b00001), .END_FIXED(5'b10000)
  ) i_seg_window_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_cs_i(wr_cs), .wr_data_i(wr_data),
    .rd_cs_i(rd_cs), .rd_data_o(rd_data), .lk_addr_i(lk_addr),
    .lk_hit_o(lk_hit), .lk_cs_o(lk_cs), .lk_off_o(lk_off),
    .err_fixed_o(f_fix), .err_reject_o(f_rej), .err_misalign_o(f_mis), .err_overlap_o(f_ov)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rnd(int m);
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return (lcg >>> 8) % m;
  endfunction

  task automatic model_write(input logic we, input int cs, input logic [31:0] d);
    int rs, re, s, e, sz;
    logic fx, rj, mi, ov;
    pend_flags = '0;
    pend_tag   = "R11";
    if (!we) return;
    if (cs >= 5) begin pend_tag = "R7"; return; end
    re = int'(d[31:24]);
    rs = int'(d[23:16]);
    if (d == {m_e[cs][7:0], m_s[cs][7:0], 16'h0000}) begin pend_tag = "R7"; return; end
    s  = (cs == 0) ? 64 : rs;
    e  = (cs == 4) ? 88 : re;
    fx = (s != rs) || (e != re);
    rj = (e <= 64) || (s > 96);
    mi = 1'b0;
    ov = 1'b0;
    if (!rj) begin
      if (e > s) begin
        sz = e - s;
        mi = (s % sz) != 0;
        for (int j = 0; j < 5; j++)
          if (j != cs && m_e[j] > m_s[j] && e > m_s[j] && s < m_e[j]) ov = 1'b1;
      end
    end
    pend_flags = {fx, rj, mi, ov};
    pend_tag = rj ? "R4" : ov ? "R6" : mi ? "R5" : fx ? "R3" : "R11";
    if (!rj) begin m_s[cs] = s; m_e[cs] = e; end
  endtask

  task automatic cyc(input logic we, input int cs, input logic [31:0] d,
                     input int rcs, input logic [30:0] a);
    logic [31:0] exp_rd;
    int g, nh, hc;
    logic [31:0] ho;
    @(negedge clk);
    wr_en = we; wr_cs = cs[2:0]; wr_data = d; rd_cs = rcs[2:0]; lk_addr = a;
    #1;
    exp_rd = (rcs < 5) ? {m_e[rcs][7:0], m_s[rcs][7:0], 16'h0000} : 32'h0;
    chk(rd_tag, rd_data, exp_rd);
    g = int'(a[30:23]);
    nh = 0; hc = 0; ho = 0;
    for (int j = 4; j >= 0; j--)
      if (m_e[j] > m_s[j] && g >= m_s[j] && g < m_e[j]) begin
        nh++; hc = j; ho = {1'b0, a} - (m_s[j] << 23);
      end
    if (nh == 0) chk("R9", {lk_hit, 1'b0, lk_cs, lk_off[26:0]}, 32'h0);
    else begin
      chk(nh > 1 ? "R10" : "R8", {31'h0, lk_hit}, 32'h1);
      chk(nh > 1 ? "R10" : "R8", {29'h0, lk_cs}, hc);
      chk("R8", {1'b0, lk_off}, {1'b0, ho[30:0]});
    end
    chk(flag_tag, {28'h0, f_fix, f_rej, f_mis, f_ov}, {28'h0, exp_flags});
    if (rst_n) model_write(we, cs, d); else begin pend_flags = '0; pend_tag = "R2"; end
    @(posedge clk);
    exp_flags = pend_flags;
    flag_tag  = pend_tag;
  endtask

  function automatic logic [31:0] sv(int e, int s, int lo = 0);
    return {e[7:0], s[7:0], lo[15:0]};
  endfunction

  function automatic logic [30:0] ad(int g, int o);
    logic [7:0]  gg = g[7:0];
    logic [22:0] oo = o[22:0];
    return {gg, oo};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // R2: defaults visible during reset
    rd_tag = "R2";
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, i, ad(64, 0));
    @(negedge clk);
    rst_n = 1'b1;
    rd_tag = "R2";
    cyc(0, 0, 0, 0, ad(64, 0));              // R8 first granule cs0
    cyc(0, 0, 0, 1, ad(72, 16));             // R8 cs1 offset
    cyc(0, 0, 0, 4, ad(87, 23'h7fffff));     // R8 last byte cs4
    cyc(0, 0, 0, 3, ad(88, 0));              // R9 just past
    cyc(0, 0, 0, 2, ad(63, 23'h7fffff));     // R9 below base
    rd_tag = "R1";
    cyc(0, 0, 0, 6, ad(80, 5));              // R1 out-of-range read
    cyc(1, 1, sv(76, 72), 1, ad(74, 1));     // R7 same value
    cyc(1, 6, sv(99, 70), 6, ad(70, 1));     // R7 out-of-range write
    cyc(1, 0, sv(72, 80), 0, ad(64, 2));     // R3 start fixed
    cyc(1, 4, sv(92, 84), 4, ad(90, 0));     // R3 end fixed
    cyc(1, 2, sv(64, 56), 2, ad(76, 0));     // R4 end at base
    cyc(1, 2, sv(99, 97), 2, ad(76, 0));     // R4 start past limit
    cyc(1, 2, sv(100, 96), 2, ad(96, 7));    // accept at limit
    cyc(1, 3, sv(83, 81), 3, ad(82, 3));     // R5 misaligned
    cyc(1, 1, sv(76, 68), 1, ad(68, 9));     // R5+R6 overlaps cs0, R10 on lookup
    cyc(0, 0, 0, 1, ad(73, 9));              // R8 cs1 after move
    cyc(1, 3, sv(88, 84, 16'habcd), 3, ad(85, 0)); // R6, R1 low bits dropped
    cyc(0, 0, 0, 3, ad(86, 4));              // R10 cs3 over cs4
    cyc(1, 3, sv(80, 80), 3, ad(80, 0));     // empty slice
    cyc(0, 0, 0, 3, ad(80, 0));              // R9 empty slice misses
    for (int k = 0; k < 600; k++) begin
      int cs, s, e;
      cs = rnd(7);
      s  = 56 + rnd(48);
      e  = s - 4 + rnd(16);
      if (rnd(8) == 0 && cs < 5) begin s = m_s[cs]; e = m_e[cs]; end
      cyc(rnd(3) != 0, cs, sv(e, s, (rnd(4) == 0) ? rnd(65536) : 0),
          rnd(6), ad(56 + rnd(48), rnd(8388608)));
    end
    cyc(0, 0, 0, 0, ad(64, 0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule